// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a three-level page table that lives in a word-addressed memory. A translation request carries the virtual address and a flag that says whether the access is a write. The walker first checks the top-level index against a table length input. It then reads one entry per level, starting from the table whose frame is given on a base input, and stops early when an entry is not marked present. It answers with a physical address or a fault. For a completed translation it also records the access in the leaf entry, writing the entry back only when that changes it.

Requests enter over a valid/ready handshake. `req_ready` is high only while the walker is idle, so a request waits, stable, until the walker can take it. The response leaves over a second valid/ready pair. Once `rsp_valid` rises, the response fields stay fixed until the consumer raises `rsp_ready`, and the walker takes no new request until then. The memory side uses a request/ack pair: address, write enable and write data are held until `mem_ack` arrives, and read data is taken in the acknowledged cycle.

Entry format, 32 bits: bit 0 present, bit 1 referenced, bit 2 modified, bits 31:12 the frame number (for a leaf) or the frame of the next table (for levels 1 and 2). The other bits are reserved as zero and are passed through unchanged.

Top module: `pt_walker`

## Requirements
- R1: While `rst_n` is low, `req_ready`, `rsp_valid` and `mem_req` are low. `req_ready` stays low in the first cycle after reset is released and rises one cycle later.
- R2: The virtual address splits into a top index in bits 31:24, a middle index in bits 23:18, a bottom index in bits 17:12 and an offset in bits 11:0. The entry for a level is read at word address {table frame, index zero-extended to 10 bits}. The top table's frame comes from `pt_base`, and each lower table's frame comes from bits 31:12 of the entry above it.
- R3: A top index greater than or equal to `pt_len` gives cause 1 (address error) with level 0 and physical address 0, and makes no memory access.
- R4: An entry whose present bit is clear ends the walk with cause 2 (page fault). `rsp_level` gives the level (1, 2 or 3) at which the walk stopped, and the walk has made exactly that many reads and no write.
- R5: A walk that reaches a present leaf gives cause 0 and level 0, with physical address {leaf bits 31:12, offset}.
- R6: After a completed translation, the leaf in memory has its referenced bit (bit 1) set.
- R7: The modified bit (bit 2) of the leaf is set by a write translation. A read translation leaves it as it was.
- R8: A completed translation makes exactly three reads. It writes the leaf back once, to the leaf's address, only when bit 1 or bit 2 changes. Otherwise it makes no write.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_paddr`, `rsp_cause` and `rsp_level` hold their values. `rsp_valid` falls in the cycle after the response is accepted.
- R10: `req_ready` is high only when the walker is idle. It is low during a walk, during the write-back and while a response is pending.
- R11: Once `mem_req` is raised, it stays high, with `mem_addr`, `mem_we` and `mem_wdata` stable, until `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pt_base | input | 20 | Frame of the top-level table |
| pt_len | input | 9 | Number of valid top-level entries |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and accepting |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | Access is a write |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer accepts response |
| rsp_paddr | output | 32 | Physical address, or 0 on a fault |
| rsp_cause | output | 2 | 0 success, 1 address error, 2 page fault |
| rsp_level | output | 2 | Level of a page fault, otherwise 0 |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 30 | Word address of the entry |
| mem_wdata | output | 32 | Updated leaf entry |
| mem_ack | input | 1 | Access done; read data valid |
| mem_rdata | input | 32 | Entry read from memory |

## Verification
The number of cycles until a response appears depends on how long the memory model delays each `mem_ack`, and the bench makes that delay random. So the bench does not wait a fixed count. It waits, at falling edges, for `rsp_valid`, which rises one cycle after the last acknowledged access, or one cycle after acceptance for an address error. Read and write counts, the result fields and the leaf word are all checked in that same cycle, because every memory effect is complete by then. The bench then holds `rsp_ready` low for a random number of cycles, checks that the response stays put, and checks that `rsp_valid` has fallen one cycle after acceptance.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int VA_W    = 32;
  localparam int OFF_W   = 12;
  localparam int L1_W    = 8;
  localparam int L2_W    = 6;
  localparam int L3_W    = 6;
  localparam int PTE_W   = 32;
  localparam int FRAME_W = VA_W - OFF_W;
  localparam int SLOT_W  = OFF_W - 2;
  localparam int MA_W    = FRAME_W + SLOT_W;
  localparam int BIT_V   = 0;
  localparam int BIT_R   = 1;
  localparam int BIT_M   = 2;

  typedef enum logic [1:0] {
    CAUSE_OK   = 2'd0,
    CAUSE_ADDR = 2'd1,
    CAUSE_PAGE = 2'd2
  } cause_e;

  typedef enum logic [2:0] {
    ST_BOOT,
    ST_IDLE,
    ST_WALK,
    ST_WB,
    ST_RSP
  } state_e;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
#(
  parameter int VA_BITS  = VA_W,
  parameter int OFS_BITS = OFF_W,
  parameter int I1_BITS  = L1_W,
  parameter int I2_BITS  = L2_W,
  parameter int I3_BITS  = L3_W
) (
  input  logic [VA_BITS-1:0]           vaddr,
  input  logic [1:0]                   level,
  input  logic [VA_BITS-OFS_BITS-1:0]  table_frame,
  input  logic [I1_BITS:0]             tbl_len,
  output logic [VA_BITS-2-1:0]         entry_addr,
  output logic                         out_of_bounds
);
  localparam int FW     = VA_BITS - OFS_BITS;
  localparam int SW     = OFS_BITS - 2;
  localparam int I3_LO  = OFS_BITS;
  localparam int I2_LO  = I3_LO + I3_BITS;
  localparam int I1_LO  = I2_LO + I2_BITS;

  logic [I1_BITS-1:0] idx1;
  logic [I2_BITS-1:0] idx2;
  logic [I3_BITS-1:0] idx3;
  logic [SW-1:0]      slot;

  assign idx1 = vaddr[I1_LO +: I1_BITS];
  assign idx2 = vaddr[I2_LO +: I2_BITS];
  assign idx3 = vaddr[I3_LO +: I3_BITS];

  always_comb begin
    unique case (level)
      2'd2:    slot = SW'(idx2);
      2'd3:    slot = SW'(idx3);
      default: slot = SW'(idx1);
    endcase
  end

  assign entry_addr    = {table_frame[FW-1:0], slot};
  assign out_of_bounds = ({1'b0, idx1} >= tbl_len);
endmodule

// File: rtl/ptw_pte_eval.sv
module ptw_pte_eval
  import ptw_pkg::*;
#(
  parameter int ENTRY_BITS = PTE_W,
  parameter int FRM_BITS   = FRAME_W
) (
  input  logic [ENTRY_BITS-1:0] pte,
  input  logic                  is_write,
  output logic                  present,
  output logic [FRM_BITS-1:0]   frame,
  output logic [ENTRY_BITS-1:0] pte_upd,
  output logic                  need_wb
);
  always_comb begin
    pte_upd        = pte;
    pte_upd[BIT_R] = 1'b1;
    if (is_write) pte_upd[BIT_M] = 1'b1;
  end

  assign present = pte[BIT_V];
  assign frame   = pte[ENTRY_BITS-1 -: FRM_BITS];
  assign need_wb = (pte_upd != pte);
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [19:0]       pt_base,
  input  logic [8:0]        pt_len,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       req_vaddr,
  input  logic              req_write,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_paddr,
  output logic [1:0]        rsp_cause,
  output logic [1:0]        rsp_level,
  output logic              mem_req,
  output logic              mem_we,
  output logic [29:0]       mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata
);
  localparam logic [1:0] LAST_LVL = 2'd3;

  state_e             state;
  logic [1:0]         lvl;
  logic [VA_W-1:0]    va_q;
  logic               wr_q;
  logic [FRAME_W-1:0] frame_q;
  logic [PTE_W-1:0]   leaf_q;

  logic [VA_W-1:0]    ag_va;
  logic [1:0]         ag_lvl;
  logic [FRAME_W-1:0] ag_frame;
  logic [MA_W-1:0]    ag_addr;
  logic               ag_oob;

  logic               pe_present;
  logic [FRAME_W-1:0] pe_frame;
  logic [PTE_W-1:0]   pe_upd;
  logic               pe_need_wb;

  logic               idle;

  assign idle     = (state == ST_IDLE);
  assign ag_va    = idle ? req_vaddr : va_q;
  assign ag_lvl   = idle ? 2'd1 : lvl;
  assign ag_frame = idle ? pt_base : frame_q;

  ptw_addr_gen #(
    .VA_BITS (VA_W),
    .OFS_BITS(OFF_W),
    .I1_BITS (L1_W),
    .I2_BITS (L2_W),
    .I3_BITS (L3_W)
  ) i_addr_gen (
    .vaddr        (ag_va),
    .level        (ag_lvl),
    .table_frame  (ag_frame),
    .tbl_len      (pt_len),
    .entry_addr   (ag_addr),
    .out_of_bounds(ag_oob)
  );

  ptw_pte_eval #(
    .ENTRY_BITS(PTE_W),
    .FRM_BITS  (FRAME_W)
  ) i_pte_eval (
    .pte     (mem_rdata),
    .is_write(wr_q),
    .present (pe_present),
    .frame   (pe_frame),
    .pte_upd (pe_upd),
    .need_wb (pe_need_wb)
  );

  assign req_ready = idle;
  assign rsp_valid = (state == ST_RSP);
  assign mem_req   = (state == ST_WALK) || (state == ST_WB);
  assign mem_we    = (state == ST_WB);
  assign mem_addr  = ag_addr;
  assign mem_wdata = leaf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_BOOT;
      lvl       <= 2'd1;
      va_q      <= '0;
      wr_q      <= 1'b0;
      frame_q   <= '0;
      leaf_q    <= '0;
      rsp_paddr <= '0;
      rsp_cause <= CAUSE_OK;
      rsp_level <= 2'd0;
    end else begin
      unique case (state)
        ST_BOOT: state <= ST_IDLE;
        ST_IDLE: begin
          if (req_valid) begin
            va_q    <= req_vaddr;
            wr_q    <= req_write;
            frame_q <= pt_base;
            lvl     <= 2'd1;
            if (ag_oob) begin
              rsp_paddr <= '0;
              rsp_cause <= CAUSE_ADDR;
              rsp_level <= 2'd0;
              state     <= ST_RSP;
            end else begin
              state <= ST_WALK;
            end
          end
        end
        ST_WALK: begin
          if (mem_ack) begin
            if (!pe_present) begin
              rsp_paddr <= '0;
              rsp_cause <= CAUSE_PAGE;
              rsp_level <= lvl;
              state     <= ST_RSP;
            end else if (lvl != LAST_LVL) begin
              frame_q <= pe_frame;
              lvl     <= lvl + 2'd1;
            end else begin
              rsp_paddr <= {pe_frame, va_q[OFF_W-1:0]};
              rsp_cause <= CAUSE_OK;
              rsp_level <= 2'd0;
              leaf_q    <= pe_upd;
              state     <= pe_need_wb ? ST_WB : ST_RSP;
            end
          end
        end
        ST_WB: begin
          if (mem_ack) state <= ST_RSP;
        end
        ST_RSP: begin
          if (rsp_ready) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> !req_ready && !rsp_valid && !mem_req); // R1

  AST_ADDR_ERR_NO_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) && rsp_cause == CAUSE_ADDR |-> $past(req_valid && req_ready)); // R3

  AST_WB_SETS_REF: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_wdata[BIT_R] && mem_wdata[BIT_V]); // R6

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr)
      && $stable(rsp_cause) && $stable(rsp_level)); // R9

  AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || mem_req) |-> !req_ready); // R10

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr)
      && $stable(mem_we) && $stable(mem_wdata)); // R11
endmodule

// File: tb/test_pt_walker.sv
module test_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] pt_base = '0;
  logic [8:0]  pt_len = 9'd256;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_cause;
  logic [1:0]  rsp_level;
  logic        mem_req;
  logic        mem_we;
  logic [29:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] mem [0:4095];
  logic        ld_en = 1'b0;
  logic [11:0] ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic        clr_cnt = 1'b0;
  int          rd_cnt = 0;
  int          wr_cnt = 0;
  int          bad_addr = 0;

  always #4 clk = ~clk;

  pt_walker i_pt_walker (
    .clk(clk), .rst_n(rst_n), .pt_base(pt_base), .pt_len(pt_len),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_paddr(rsp_paddr), .rsp_cause(rsp_cause), .rsp_level(rsp_level),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  // Memory model: ack after a random delay, one cycle wide
  always @(posedge clk) begin
    if (ld_en) mem[ld_addr] <= ld_data;
    else if (mem_req && mem_we && mem_ack) mem[mem_addr[11:0]] <= mem_wdata;
    if (!rst_n) mem_ack <= 1'b0;
    else mem_ack <= mem_req && !mem_ack && ($urandom_range(0, 2) != 0);
    mem_rdata <= mem[mem_addr[11:0]];
    if (clr_cnt) begin
      rd_cnt <= 0; wr_cnt <= 0; bad_addr <= 0;
    end else begin
      if (mem_req && mem_ack && !mem_we) rd_cnt <= rd_cnt + 1;
      if (mem_req && mem_ack && mem_we) wr_cnt <= wr_cnt + 1;
      if (mem_req && mem_addr[29:12] != 0) bad_addr <= bad_addr + 1;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  // One translation; tables at frames 0, 1, 2
  task automatic run_one(input logic [31:0] va, input bit w, input logic [8:0] len,
                         input logic [31:0] e1, input logic [31:0] e2, input logic [31:0] e3);
    logic [7:0]  i1 = va[31:24];
    logic [5:0]  i2 = va[23:18];
    logic [5:0]  i3 = va[17:12];
    logic [11:0] a3 = 12'd2048 + 12'(i3);
    logic [1:0]  x_cause; logic [1:0] x_lvl; logic [31:0] x_pa; logic [31:0] x_leaf;
    int x_rd; int x_wr;
    logic [31:0] c_pa; logic [1:0] c_cause; logic [1:0] c_lvl;
    int stall;
    load(12'(i1), e1);
    load(12'd1024 + 12'(i2), e2);
    load(a3, e3);
    @(negedge clk); clr_cnt = 1'b1; pt_len = len; pt_base = 20'd0;
    @(negedge clk); clr_cnt = 1'b0;
    x_pa = 0; x_lvl = 0; x_leaf = e3; x_wr = 0;
    if ({1'b0, i1} >= len) begin x_cause = 1; x_rd = 0; end
    else if (!e1[0]) begin x_cause = 2; x_lvl = 1; x_rd = 1; end
    else if (!e2[0]) begin x_cause = 2; x_lvl = 2; x_rd = 2; end
    else if (!e3[0]) begin x_cause = 2; x_lvl = 3; x_rd = 3; end
    else begin
      x_cause = 0; x_rd = 3;
      x_leaf = e3 | 32'h2 | (w ? 32'h4 : 32'h0);
      x_wr = (x_leaf != e3) ? 1 : 0;
      x_pa = {e3[31:12], va[11:0]};
    end
    req_vaddr = va; req_write = w; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, "R10 ready low after accept", req_ready, 0);
    while (!rsp_valid) @(negedge clk);
    check(rsp_cause == x_cause, "R3/R4/R5 cause", rsp_cause, x_cause);
    check(rsp_level == x_lvl, "R4 level", rsp_level, x_lvl);
    check(rsp_paddr == x_pa, "R5 paddr", rsp_paddr, x_pa);
    check(rd_cnt == x_rd, "R8 read count", rd_cnt, x_rd);
    check(wr_cnt == x_wr, "R8 write count", wr_cnt, x_wr);
    check(mem[a3] == x_leaf, "R6 R7 leaf word", mem[a3], x_leaf);
    check(bad_addr == 0, "R2 entry address range", bad_addr, 0);
    check(!req_ready, "R10 ready low while response pending", req_ready, 0);
    c_pa = rsp_paddr; c_cause = rsp_cause; c_lvl = rsp_level;
    stall = $urandom_range(0, 3);
    for (int k = 0; k < stall; k++) begin
      @(negedge clk);
      check(rsp_valid && rsp_paddr == c_pa && rsp_cause == c_cause && rsp_level == c_lvl,
            "R9 hold under back-pressure", {rsp_valid, rsp_paddr}, {1'b1, c_pa});
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check(!rsp_valid, "R9 valid falls after accept", rsp_valid, 0);
  endtask

  function automatic logic [31:0] pte(input logic [19:0] f, input bit m, input bit r, input bit v);
    return {f, 9'd0, m, r, v};
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] va;
    void'($urandom(32'h00C0FFEE));
    for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    check(!req_ready && !rsp_valid && !mem_req, "R1 outputs low in reset",
          {req_ready, rsp_valid, mem_req}, 0);
    rst_n = 1'b1;
    check(!req_ready, "R1 ready low right after release", req_ready, 0);
    @(negedge clk);
    @(negedge clk);
    check(req_ready, "R1 ready high when idle", req_ready, 1);

    // Directed corners
    run_one(32'h0000_0123, 1'b0, 9'd0,   pte(1,0,0,1), pte(2,0,0,1), pte(20'hABCDE,0,0,1)); // R3 length zero
    run_one(32'h0500_0000, 1'b0, 9'd5,   pte(1,0,0,1), pte(2,0,0,1), pte(20'h11111,0,0,1)); // R3 index equals length
    run_one(32'h0500_0FFF, 1'b0, 9'd6,   pte(1,0,0,1), pte(2,0,0,1), pte(20'h22222,0,0,1)); // R5 just inside
    run_one(32'hFFFF_FABC, 1'b1, 9'd256, pte(1,0,0,1), pte(2,0,0,1), pte(20'hFFFFF,0,0,1)); // R2 top corner
    run_one(32'h1234_5678, 1'b0, 9'd256, pte(1,0,0,0), pte(2,0,0,1), pte(20'h33333,0,0,1)); // R4 level 1
    run_one(32'h1234_5678, 1'b0, 9'd256, pte(1,0,0,1), pte(2,0,0,0), pte(20'h33333,0,0,1)); // R4 level 2
    run_one(32'h1234_5678, 1'b1, 9'd256, pte(1,0,0,1), pte(2,0,0,1), pte(20'h33333,0,0,0)); // R4 level 3
    run_one(32'h2200_1000, 1'b1, 9'd256, pte(1,0,0,1), pte(2,0,0,1), pte(20'h44444,1,1,1)); // R8 no change
    run_one(32'h2200_2000, 1'b0, 9'd256, pte(1,0,0,1), pte(2,0,0,1), pte(20'h55555,0,1,1)); // R8 read, ref set
    run_one(32'h2200_3000, 1'b0, 9'd256, pte(1,0,0,1), pte(2,0,0,1), pte(20'h66666,0,0,1)); // R7 read keeps M
    run_one(32'h2200_4000, 1'b1, 9'd256, pte(1,0,0,1), pte(2,0,0,1), pte(20'h77777,0,0,1)); // R7 write sets M

    // Random mix
    for (int n = 0; n < 200; n++) begin
      va = $urandom();
      run_one(va, 1'($urandom_range(0, 1)), 9'($urandom_range(0, 256)),
              pte(1, 0, 0, $urandom_range(0, 9) != 0),
              pte(2, 0, 0, $urandom_range(0, 9) != 0),
              pte(20'($urandom()), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                  $urandom_range(0, 9) != 0));
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule